// File: doc/BRIEF.md
# Split-Register 32-bit Interval Timer

This block is an up-counting interval timer whose 32-bit limit and count are visible to software only through a 16-bit register bus. Each wide value occupies two 16-bit locations. The low half sits at the base offset and the high half sits 4 bytes above it. Software loads the limit one half at a time and starts the timer with a self-clearing start bit. While the timer is armed and not held, the counter advances by one on every cycle in which the tick enable input is high. When the count has reached the limit, the next tick returns it to zero. If interrupts are enabled, that wrap also sets a sticky interrupt flag.

The live count cannot be read directly, because it could carry between the two half-word reads. A self-clearing capture bit copies all 32 bits of the count into a shadow register in a single cycle. The two count offsets return halves of that shadow, so a pair of reads always describes one instant. The bus read path is combinational, and writes take effect at the clock edge of the write cycle. The divider that produces the tick and the choice of timer clock are outside this block.

Top module: `split_half_timer`

## Requirements
- R1: After reset every register is zero. Reads of the control, limit and count offsets return 0, and irqOut is 0.
- R2: Control register at offset 0x00. Bit 0 is a hold bit (1 stops counting). Bit 1 is start, bit 3 is clear and bit 4 is capture; these three act only in the write cycle and always read back 0. Bit 8 is interrupt enable. Bit 9 reads the interrupt flag, and writing 1 to bit 9 clears it.
- R3: The 32-bit limit is read/write as a low half at offset 0x08 and a high half at offset 0x0C.
- R4: Writing 1 to start sets the count to 0 and arms the timer. Before the first start, ticks leave the count at 0.
- R5: While armed with the hold bit 0, each cycle with tickEn high adds one to the count, and the carry crosses from the low half into the high half. The count holds when tickEn is low, when the hold bit is 1, or when unarmed. The hold bit and interrupt enable written in a cycle take effect from the next cycle.
- R6: A tick that finds the count equal to the limit sets the count to 0 instead of incrementing it. With limit 0, every tick wraps.
- R7: A wrap with interrupt enable set makes the interrupt flag 1, and irqOut follows the flag. A wrap with interrupt enable clear leaves the flag unchanged. In a cycle where both a setting wrap and a write-1-to-clear occur, the set wins.
- R8: Writing 1 to clear sets the count to 0 at that edge and does not change the armed state. Start and clear suppress a tick in the same cycle.
- R9: Writing 1 to capture copies the count as it was before that edge into a shadow register. Offset 0x10 reads the low half of the shadow and offset 0x14 reads the high half. The shadow changes only on capture.
- R10: Reads of any other offset return 0. Writes to the count offsets, or to undefined offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| tickEn | input | 1 | Count enable pulse at the reference rate |
| irqOut | output | 1 | Interrupt, level of the sticky flag |

## Verification
The bench targets these corner cases:
- A limit whose low half is small and whose high half is 1. The count must carry across the 16-bit boundary; a design that splits the counter, or compares only the low half, would wrap early or read back a torn value.
- Capture issued in the same cycle as a tick. A design that snapshots the post-increment value would be off by one.
- Ticks arriving before any start.
- Start or clear coinciding with a tick.
- Limit zero.
- A wrap in the same cycle as a write-1-to-clear. A design that lets the clear win would drop an interrupt.
- Writes to the read-only count offsets, which must not disturb the shadow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // One-cycle actions decoded from a control write
  typedef struct packed {
    logic start;
    logic clear;
    logic capture;
    logic ackIrq;
  } tmrStrobe_t;

  localparam int CTRL_HOLD_BIT  = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int CTRL_CLEAR_BIT = 3;
  localparam int CTRL_CAPT_BIT  = 4;
  localparam int CTRL_IRQEN_BIT = 8;
  localparam int CTRL_FLAG_BIT  = 9;

  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_LIMIT   = 'h08;
  localparam int OFS_COUNT   = 'h10;
  localparam int HALF_STRIDE = 4;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int HALF_W     = 16,
  parameter int NUM_HALVES = 2,
  localparam int CNT_W     = HALF_W * NUM_HALVES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  shadow,
  input  logic              irqFlag,
  output tmrStrobe_t        stb,
  output logic              holdBit,
  output logic              irqEn,
  output logic [CNT_W-1:0]  limitVal
);

  logic ctrlHit;
  logic [HALF_W-1:0] limitHalf [NUM_HALVES];
  logic unusedCtrlBits;

  assign ctrlHit = busWe && (busAddr == ADDR_W'(OFS_CTRL));

  assign stb.start   = ctrlHit && busWdata[CTRL_START_BIT];
  assign stb.clear   = ctrlHit && busWdata[CTRL_CLEAR_BIT];
  assign stb.capture = ctrlHit && busWdata[CTRL_CAPT_BIT];
  assign stb.ackIrq  = ctrlHit && busWdata[CTRL_FLAG_BIT];

  assign unusedCtrlBits = ^{busWdata[HALF_W-1:CTRL_FLAG_BIT+1],
                            busWdata[CTRL_IRQEN_BIT-1:CTRL_CAPT_BIT+1],
                            busWdata[CTRL_CLEAR_BIT-1:CTRL_START_BIT+1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBit <= 1'b0;
      irqEn   <= 1'b0;
    end else if (ctrlHit) begin
      holdBit <= busWdata[CTRL_HOLD_BIT];
      irqEn   <= busWdata[CTRL_IRQEN_BIT];
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_limit
    logic halfHit;
    assign halfHit = busWe && (busAddr == ADDR_W'(OFS_LIMIT + h * HALF_STRIDE));
    always_ff @(posedge clk) begin
      if (!rstN)        limitHalf[h] <= '0;
      else if (halfHit) limitHalf[h] <= busWdata;
    end
    assign limitVal[h*HALF_W +: HALF_W] = limitHalf[h];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_CTRL)) begin
      busRdata[CTRL_HOLD_BIT]  = holdBit;
      busRdata[CTRL_IRQEN_BIT] = irqEn;
      busRdata[CTRL_FLAG_BIT]  = irqFlag;
    end
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (busAddr == ADDR_W'(OFS_LIMIT + h * HALF_STRIDE)) busRdata = limitHalf[h];
      if (busAddr == ADDR_W'(OFS_COUNT + h * HALF_STRIDE)) busRdata = shadow[h*HALF_W +: HALF_W];
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic             tickEn,
  input  logic             holdBit,
  input  logic             irqEn,
  input  logic [CNT_W-1:0] limitVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] shadow,
  output logic             armed,
  output logic             irqFlag
);

  logic advance;
  logic atLimit;
  logic wrapEvt;

  assign advance = armed && !holdBit && tickEn && !stb.start && !stb.clear;
  assign atLimit = (count == limitVal);
  assign wrapEvt = advance && atLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      armed <= 1'b0;
    end else if (stb.start) begin
      count <= '0;
      armed <= 1'b1;
    end else if (stb.clear) begin
      count <= '0;
    end else if (advance) begin
      count <= atLimit ? '0 : count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            shadow <= '0;
    else if (stb.capture) shadow <= count;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  irqFlag <= 1'b0;
    else if (wrapEvt && irqEn)  irqFlag <= 1'b1;
    else if (stb.ackIrq)        irqFlag <= 1'b0;
  end

endmodule

// File: rtl/split_half_timer.sv
module split_half_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  input  logic              tickEn,
  output logic              irqOut
);

  localparam int NUM_HALVES = 2;
  localparam int CNT_W      = HALF_W * NUM_HALVES;

  tmrStrobe_t       stb;
  logic             holdBit;
  logic             irqEn;
  logic             armed;
  logic             irqFlag;
  logic [CNT_W-1:0] limitVal;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shadow;

  tmr_ctrl #(
    .ADDR_W    (ADDR_W),
    .HALF_W    (HALF_W),
    .NUM_HALVES(NUM_HALVES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .shadow  (shadow),
    .irqFlag (irqFlag),
    .stb     (stb),
    .holdBit (holdBit),
    .irqEn   (irqEn),
    .limitVal(limitVal)
  );

  tmr_datapath #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .tickEn  (tickEn),
    .holdBit (holdBit),
    .irqEn   (irqEn),
    .limitVal(limitVal),
    .count   (count),
    .shadow  (shadow),
    .armed   (armed),
    .irqFlag (irqFlag)
  );

  assign irqOut = irqFlag;

endmodule

// File: rtl/split_half_timer_chk.sv
module split_half_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             irqOut,
  input tmrStrobe_t       stb,
  input logic             holdBit,
  input logic             irqEn,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] shadow,
  input logic [CNT_W-1:0] limitVal
);

  logic stepOk;
  logic wrapNow;
  assign stepOk  = armed && !holdBit && tickEn && !stb.start && !stb.clear;
  assign wrapNow = stepOk && (count == limitVal);

  // R4
  start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (count == '0) && armed);

  // R4
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (count == '0));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && !stb.start) |=> (count == '0) && (armed == $past(armed)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.start && !stb.clear && !stepOk) |=> $stable(count));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && (count != limitVal)) |=> (count == $past(count) + CNT_W'(1)));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> (count == '0));

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (shadow == $past(count)));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(shadow));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrapNow && irqEn) |=> irqOut);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(irqEn));

  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackIrq && !(wrapNow && irqEn)) |=> !irqOut);

endmodule

bind split_half_timer split_half_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .irqOut  (irqOut),
  .stb     (stb),
  .holdBit (holdBit),
  .irqEn   (irqEn),
  .armed   (armed),
  .count   (count),
  .shadow  (shadow),
  .limitVal(limitVal)
);

// File: tb/split_half_timer_tb_top.sv
module split_half_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        tickEn = 1'b0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  // Reference model state
  logic [31:0] mCount = '0, mShadow = '0, mLimit = '0;
  logic        mArmed = 1'b0, mHold = 1'b0, mIrqEn = 1'b0, mFlag = 1'b0;

  always #4 clk = ~clk;

  split_half_timer dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn), .irqOut(irqOut)
  );

  function automatic logic [15:0] expRead(input logic [7:0] a);
    case (a)
      8'h00:   return {6'b0, mFlag, mIrqEn, 7'b0, mHold};
      8'h08:   return mLimit[15:0];
      8'h0C:   return mLimit[31:16];
      8'h10:   return mShadow[15:0];
      8'h14:   return mShadow[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h00:        return "R2";
      8'h08, 8'h0C: return "R3";
      8'h10, 8'h14: return "R9";
      default:      return "R10";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic we, input logic [7:0] a, input logic [15:0] d, input logic tk);
    logic st, cl, cp, ak, adv, wrap;
    st   = we && a == 8'h00 && d[1];
    cl   = we && a == 8'h00 && d[3];
    cp   = we && a == 8'h00 && d[4];
    ak   = we && a == 8'h00 && d[9];
    adv  = mArmed && !mHold && tk && !st && !cl;
    wrap = adv && (mCount == mLimit);
    if (cp) mShadow = mCount;
    if (wrap && mIrqEn) mFlag = 1'b1;
    else if (ak)        mFlag = 1'b0;
    if (st) begin mCount = '0; mArmed = 1'b1; end
    else if (cl)  mCount = '0;
    else if (adv) mCount = wrap ? 32'h0 : mCount + 32'h1;
    if (we && a == 8'h00) begin mHold = d[0]; mIrqEn = d[8]; end
    if (we && a == 8'h08) mLimit[15:0]  = d;
    if (we && a == 8'h0C) mLimit[31:16] = d;
  endtask

  // One clock: drive at negedge, check combinational read and irq, advance model
  task automatic step(input logic we, input logic [7:0] a, input logic [15:0] d,
                      input logic tk, input string tag);
    busWe = we; busAddr = a; busWdata = d; tickEn = tk;
    #1;
    chk(32'(busRdata), 32'(expRead(a)), (tag == "") ? tagFor(a) : tag);
    chk(32'(irqOut), 32'(mFlag), (tag == "") ? "R7" : tag);
    modelStep(we, a, d, tk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 16'h0, tk, "");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R5 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  a;
    logic [7:0]  rdSet [7];
    void'($urandom(32'd4711));
    rdSet = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h04, 8'h18};

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state through every defined offset
    step(1'b0, 8'h00, 16'h0, 1'b0, "R1");
    step(1'b0, 8'h08, 16'h0, 1'b0, "R1");
    step(1'b0, 8'h0C, 16'h0, 1'b0, "R1");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R1");
    step(1'b0, 8'h14, 16'h0, 1'b0, "R1");

    // R4: ticks before start do nothing
    idle(5, 1'b1);
    step(1'b1, 8'h00, 16'h0010, 1'b1, "R4");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R4");

    // R3, R5: limit 5, start with irq enabled, three ticks then capture
    step(1'b1, 8'h08, 16'h0005, 1'b0, "R3");
    step(1'b0, 8'h08, 16'h0, 1'b0, "R3");
    step(1'b1, 8'h00, 16'h0102, 1'b1, "R4");
    idle(3, 1'b1);
    step(1'b0, 8'h00, 16'h0, 1'b0, "R5");
    step(1'b1, 8'h00, 16'h0110, 1'b1, "R5");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R5");

    // R6, R7: run to wrap, flag rises
    idle(3, 1'b1);
    step(1'b0, 8'h00, 16'h0, 1'b0, "R7");
    step(1'b1, 8'h00, 16'h0110, 1'b0, "R6");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R6");

    // R7: write-1-to-clear
    step(1'b1, 8'h00, 16'h0300, 1'b0, "R7");
    step(1'b0, 8'h00, 16'h0, 1'b0, "R7");

    // R5: hold bit stops counting
    step(1'b1, 8'h00, 16'h0101, 1'b1, "R5");
    idle(4, 1'b1);
    step(1'b1, 8'h00, 16'h0111, 1'b1, "R5");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R5");

    // R8: clear with a coincident tick
    step(1'b1, 8'h00, 16'h0100, 1'b1, "R8");
    idle(2, 1'b1);
    step(1'b1, 8'h00, 16'h0108, 1'b1, "R8");
    step(1'b1, 8'h00, 16'h0110, 1'b0, "R8");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R8");

    // R10: undefined offsets and count writes
    step(1'b1, 8'h10, 16'hFFFF, 1'b0, "R10");
    step(1'b1, 8'h14, 16'hFFFF, 1'b0, "R10");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R10");
    step(1'b0, 8'h14, 16'h0, 1'b0, "R10");
    step(1'b1, 8'h04, 16'hABCD, 1'b0, "R10");
    step(1'b0, 8'h04, 16'h0, 1'b0, "R10");
    step(1'b0, 8'h1C, 16'h0, 1'b0, "R10");
    step(1'b0, 8'h80, 16'h0, 1'b0, "R10");

    // R9: carry across halves, limit 0x0001_0002, irq disabled
    step(1'b1, 8'h08, 16'h0002, 1'b0, "R3");
    step(1'b1, 8'h0C, 16'h0001, 1'b0, "R3");
    step(1'b1, 8'h00, 16'h0002, 1'b1, "R4");
    idle(65537, 1'b1);
    step(1'b1, 8'h00, 16'h0010, 1'b1, "R9");
    step(1'b0, 8'h10, 16'h0, 1'b1, "R9");
    step(1'b0, 8'h14, 16'h0, 1'b1, "R9");
    step(1'b0, 8'h00, 16'h0, 1'b0, "R7");
    step(1'b1, 8'h00, 16'h0010, 1'b0, "R6");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R6");
    step(1'b0, 8'h14, 16'h0, 1'b0, "R6");

    // R6: limit zero wraps every tick, with interrupt
    step(1'b1, 8'h0C, 16'h0000, 1'b0, "R3");
    step(1'b1, 8'h08, 16'h0000, 1'b0, "R3");
    step(1'b1, 8'h00, 16'h0102, 1'b0, "R4");
    idle(3, 1'b1);
    step(1'b1, 8'h00, 16'h0110, 1'b0, "R6");
    step(1'b0, 8'h10, 16'h0, 1'b0, "R6");
    step(1'b0, 8'h00, 16'h0, 1'b0, "R7");

    // R7: wrap coincides with write-1-to-clear; set wins
    step(1'b1, 8'h00, 16'h0300, 1'b1, "R7");
    step(1'b0, 8'h00, 16'h0, 1'b0, "R7");

    // Random mix
    step(1'b1, 8'h08, 16'h0007, 1'b0, "R3");
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom % 16;
      a = rdSet[$urandom % 7];
      if (sel < 10) begin
        step(1'b0, a, 16'h0, 1'($urandom), "");
      end else if (sel == 10) begin
        d = 16'($urandom) & 16'h031B;
        if ($urandom % 4 != 0) d[0] = 1'b0;
        step(1'b1, 8'h00, d, 1'($urandom), "");
      end else if (sel == 11) begin
        step(1'b1, 8'h08, 16'($urandom % 12), 1'($urandom), "");
      end else if (sel == 12) begin
        step(1'b1, 8'h0C, ($urandom % 8 == 0) ? 16'h0001 : 16'h0000, 1'($urandom), "");
      end else if (sel == 13) begin
        d = {7'b0, mIrqEn, 7'b0010000, mHold};
        step(1'b1, 8'h00, d, 1'($urandom), "");
      end else if (sel == 14) begin
        d = {7'b0, mIrqEn, 7'b0000010, 1'b0};
        step(1'b1, 8'h00, d, 1'($urandom), "");
      end else begin
        step(1'b1, ($urandom % 2 == 0) ? 8'h10 : 8'h14, 16'($urandom), 1'($urandom), "");
      end
    end

    summary();
    $finish;
  end

endmodule